// File: doc/BRIEF.md
# Serial EEPROM Command Engine with Block Lock

This block is the command side of a small serial EEPROM. A host talks to it over a four-wire SPI link in clock mode 0 or mode 3. Each transfer starts with an 8-bit command sent most significant bit first. The engine keeps a byte array in registers. It accepts a 16-bit start address for sequential reads and page writes. It also holds an 8-bit status register covering write enable, a user flag, two watchdog-interval bits, two block-lock bits and a lock for the status register itself.

All SPI pins are brought into the system clock domain through synchronizers, so the system clock must run several times faster than SCK. A page write or status write is buffered during the transfer. It takes effect only when chip-select rises on a byte boundary. It then starts a modelled self-timed write cycle that keeps a busy bit set for `WR_TICKS` clock cycles. While the cycle runs, only the status read is served.

Top module: `eep_cmd_engine`

## Requirements
- R1: After reset the status byte reads 0x30 (watchdog bits 11, block-lock bits 00, all other bits 0). `spi_miso_oe` is low whenever chip-select is high.
- R2: Command bytes: 0x06 sets the write-enable bit (bit 1). 0x04 clears both write-enable and the flag (bit 6). 0x00 sets the flag. 0x05 returns the status byte, whose bits from 7 down to 0 are status-lock enable, flag, watchdog 1, watchdog 0, block-lock 1, block-lock 0, write enable, busy. The status byte repeats for as long as clocks continue.
- R3: Input is sampled on rising SCK and output changes on falling SCK, both MSB first. Transfers behave the same in mode 0 (SCK idles low) and mode 3 (SCK idles high).
- R4: Command 0x03 takes a 16-bit address, high byte first, and returns consecutive bytes. Address bits above bit 11 are ignored, and the address wraps from 0x0FFF to 0x0000.
- R5: A page write (0x02) or status write (0x01) issued while write-enable is 0 changes nothing.
- R6: During a page write the address wraps within its 32-byte page (the low 5 address bits).
- R7: A page write commits only if chip-select rises right after bit 0 of a data byte, with at least one data byte sent. Otherwise the array is unchanged, no write cycle starts and write-enable stays set.
- R8: A committed write sets busy for `WR_TICKS` clock cycles. During that time the status read works and every other command is ignored. Write-enable is 0 once the cycle ends.
- R9: Block-lock bits 01 protect 0x0C00-0x0FFF, 10 protect 0x0800-0x0FFF and 11 protect the whole array. Writes to protected bytes are dropped, and those bytes remain readable.
- R10: A status write updates only bits 7, 5, 4, 3 and 2. Flag, write-enable and busy are unaffected by the data byte.
- R11: With `wp_n` low and status bit 7 set, status writes are refused and write-enable stays set. With bit 7 clear, `wp_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Active-low chip-select |
| spi_mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low status write-protect pin |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high impedance |

## Verification
Each SPI pin change reaches the engine's edge detector three system clocks later: two synchronizer stages plus one edge flop. A completed byte is decoded one clock after its eighth rising edge, and the next output bit appears on `spi_miso` one clock after the falling edge is detected. The bench holds each SCK phase for six clocks and reads `spi_miso` just before it raises SCK, so every output bit has settled by then. A commit happens on the detected chip-select rise and busy follows one clock later. Busy-phase checks therefore run a status read straight after the write, and settled checks wait `WR_TICKS` plus a margin before reading back.

// File: rtl/eep_pkg.sv
package eep_pkg;
   // command codes
   localparam logic [7:0] OP_SETFLAG = 8'h00;
   localparam logic [7:0] OP_WRSTAT  = 8'h01;
   localparam logic [7:0] OP_WRITE   = 8'h02;
   localparam logic [7:0] OP_READ    = 8'h03;
   localparam logic [7:0] OP_CLRWEL  = 8'h04;
   localparam logic [7:0] OP_RDSTAT  = 8'h05;
   localparam logic [7:0] OP_SETWEL  = 8'h06;

   // transfer phase of the current chip-select window
   typedef enum logic [3:0] {
      PH_OP, PH_AHI, PH_ALO, PH_RDAT, PH_WDAT,
      PH_STAT, PH_SDAT, PH_SDONE, PH_DROP
   } phase_e;
endpackage

// File: rtl/eep_spi_port.sv
module eep_spi_port #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck,
   input  logic       cs_n,
   input  logic       mosi,
   input  logic [7:0] tx_byte,
   output logic [7:0] rx_byte,
   output logic       byte_done,
   output logic       bit_rise,
   output logic       sel_start,
   output logic       sel_end,
   output logic       on_boundary,
   output logic       miso,
   output logic       miso_oe
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sck_sr, cs_sr, mosi_sr;
   logic sck_q, cs_q;
   logic sck_s, cs_s, mosi_s;
   logic [2:0] bitcnt;
   logic [7:0] rx_sh;
   logic [6:0] tx_sh;
   logic miso_r;
   logic fall;

   assign sck_s  = sck_sr[SYNC_STAGES-1];
   assign cs_s   = cs_sr[SYNC_STAGES-1];
   assign mosi_s = mosi_sr[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_sr  <= '0;
         cs_sr   <= '1;
         mosi_sr <= '0;
         sck_q   <= 1'b0;
         cs_q    <= 1'b1;
      end else begin
         sck_sr  <= {sck_sr[SYNC_STAGES-2:0], sck};
         cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
         mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
         sck_q   <= sck_s;
         cs_q    <= cs_s;
      end
   end

   assign bit_rise  = sck_s & ~sck_q & ~cs_s;
   assign fall      = ~sck_s & sck_q & ~cs_s;
   assign sel_start = ~cs_s & cs_q;
   assign sel_end   = cs_s & ~cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt    <= '0;
         rx_sh     <= '0;
         byte_done <= 1'b0;
         tx_sh     <= '0;
         miso_r    <= 1'b0;
      end else begin
         byte_done <= bit_rise && (bitcnt == 3'd7);
         if (cs_s) begin
            bitcnt <= '0;
         end else if (bit_rise) begin
            bitcnt <= bitcnt + 3'd1;
            rx_sh  <= {rx_sh[6:0], mosi_s};
         end
         if (fall) begin
            if (bitcnt == 3'd0) begin
               miso_r <= tx_byte[7];
               tx_sh  <= tx_byte[6:0];
            end else begin
               miso_r <= tx_sh[6];
               tx_sh  <= {tx_sh[5:0], 1'b0};
            end
         end
      end
   end

   assign rx_byte     = rx_sh;
   assign on_boundary = (bitcnt == 3'd0);
   assign miso        = miso_r;
   assign miso_oe     = ~cs_s;

   // a finished byte always leaves the bit counter on a boundary
   assert_byte_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |-> on_boundary);
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
   parameter int unsigned TICKS = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   if (TICKS < 1) begin : g_bad_ticks
      $error("TICKS must be at least 1");
   end

   localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
   localparam logic [CW-1:0] LOAD = CW'(TICKS - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (cnt == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end else if (start) begin
            busy <= 1'b1;
            cnt  <= LOAD;
         end
      end
   end

   assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0) |=> busy);
   assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: rtl/eep_guard.sv
module eep_guard (
   input  logic [1:0] bl,
   input  logic [1:0] quarter,
   input  logic       wpen,
   input  logic       wp_n,
   output logic       byte_lock,
   output logic       sr_lock
);
   always_comb begin
      unique case (bl)
         2'b00:   byte_lock = 1'b0;
         2'b01:   byte_lock = &quarter;
         2'b10:   byte_lock = quarter[1];
         default: byte_lock = 1'b1;
      endcase
   end

   assign sr_lock = wpen & ~wp_n;
endmodule

// File: rtl/eep_cmd_engine.sv
module eep_cmd_engine
   import eep_pkg::*;
#(
   parameter int          ADDR_W      = 12,
   parameter int          PAGE_W      = 5,
   parameter int unsigned WR_TICKS    = 500000,
   parameter int          SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   input  logic wp_n,
   output logic spi_miso,
   output logic spi_miso_oe
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int PAGE  = 1 << PAGE_W;
   localparam int HI_W  = ADDR_W - 8;

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
      $error("ADDR_W must lie in 9..16");
   end
   if (PAGE_W < 1 || PAGE_W > ADDR_W - 2) begin : g_bad_pw
      $error("PAGE_W must leave a page inside one quarter");
   end

   logic [7:0] rx_byte, tx_next;
   logic byte_done, bit_rise, sel_start, sel_end, on_boundary;
   logic wip, wt_done, wt_start;
   logic page_lock, sr_lock;
   logic [1:0] wp_sr;
   logic wp_s;

   phase_e            phase;
   logic              is_wr;
   logic [HI_W-1:0]   addr_hi;
   logic [ADDR_W-1:0] cur_addr, nxt_addr;
   logic [PAGE_W-1:0] slot;
   logic [PAGE-1:0]   page_vld;
   logic [7:0]        page_buf [PAGE];
   logic [7:0]        mem [DEPTH];

   logic       st_wpen, st_flag, st_wel;
   logic [1:0] st_wd, st_bl;
   logic       sr_wpen;
   logic [1:0] sr_wd, sr_bl;
   logic [7:0] status_byte;
   logic       commit_wr, commit_sr;

   eep_spi_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck        (spi_sck),
      .cs_n       (spi_cs_n),
      .mosi       (spi_mosi),
      .tx_byte    (tx_next),
      .rx_byte    (rx_byte),
      .byte_done  (byte_done),
      .bit_rise   (bit_rise),
      .sel_start  (sel_start),
      .sel_end    (sel_end),
      .on_boundary(on_boundary),
      .miso       (spi_miso),
      .miso_oe    (spi_miso_oe)
   );

   eep_wtimer #(.TICKS(WR_TICKS)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .start(wt_start),
      .busy (wip),
      .done (wt_done)
   );

   eep_guard u_guard (
      .bl       (st_bl),
      .quarter  (cur_addr[ADDR_W-1:ADDR_W-2]),
      .wpen     (st_wpen),
      .wp_n     (wp_s),
      .byte_lock(page_lock),
      .sr_lock  (sr_lock)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wp_sr <= 2'b11;
      else        wp_sr <= {wp_sr[0], wp_n};
   end
   assign wp_s = wp_sr[1];

   assign status_byte = {st_wpen, st_flag, st_wd, st_bl, st_wel, wip};
   assign nxt_addr    = cur_addr + 1'b1;
   assign slot        = cur_addr[PAGE_W-1:0];
   assign commit_wr   = sel_end && (phase == PH_WDAT) && on_boundary
                        && (|page_vld) && !wip;
   assign commit_sr   = sel_end && (phase == PH_SDONE) && on_boundary
                        && !sr_lock && !wip;
   assign wt_start    = commit_wr | commit_sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_DROP;
         is_wr    <= 1'b0;
         addr_hi  <= '0;
         cur_addr <= '0;
         page_vld <= '0;
         tx_next  <= '0;
         sr_wpen  <= 1'b0;
         sr_wd    <= 2'b00;
         sr_bl    <= 2'b00;
         st_wpen  <= 1'b0;
         st_flag  <= 1'b0;
         st_wel   <= 1'b0;
         st_wd    <= 2'b11;
         st_bl    <= 2'b00;
      end else begin
         if (phase == PH_STAT) tx_next <= status_byte;
         if (sel_start) begin
            phase    <= PH_OP;
            page_vld <= '0;
         end else if (sel_end) begin
            if (commit_sr) begin
               st_wpen <= sr_wpen;
               st_wd   <= sr_wd;
               st_bl   <= sr_bl;
            end
            phase <= PH_DROP;
         end else if (byte_done) begin
            unique case (phase)
               PH_OP: begin
                  phase <= PH_DROP;
                  if (!wip || rx_byte == OP_RDSTAT) begin
                     case (rx_byte)
                        OP_SETWEL:  st_wel <= 1'b1;
                        OP_CLRWEL: begin
                           st_wel  <= 1'b0;
                           st_flag <= 1'b0;
                        end
                        OP_SETFLAG: st_flag <= 1'b1;
                        OP_RDSTAT: begin
                           tx_next <= status_byte;
                           phase   <= PH_STAT;
                        end
                        OP_WRSTAT: if (st_wel) phase <= PH_SDAT;
                        OP_READ: begin
                           is_wr <= 1'b0;
                           phase <= PH_AHI;
                        end
                        OP_WRITE: if (st_wel) begin
                           is_wr <= 1'b1;
                           phase <= PH_AHI;
                        end
                        default: phase <= PH_DROP;
                     endcase
                  end
               end
               PH_AHI: begin
                  addr_hi <= rx_byte[HI_W-1:0];
                  phase   <= PH_ALO;
               end
               PH_ALO: begin
                  cur_addr <= {addr_hi, rx_byte};
                  if (is_wr) begin
                     phase <= PH_WDAT;
                  end else begin
                     tx_next <= mem[{addr_hi, rx_byte}];
                     phase   <= PH_RDAT;
                  end
               end
               PH_RDAT: begin
                  cur_addr <= nxt_addr;
                  tx_next  <= mem[nxt_addr];
               end
               PH_WDAT: begin
                  page_vld[slot]           <= 1'b1;
                  cur_addr[PAGE_W-1:0]     <= slot + 1'b1;
               end
               PH_SDAT: begin
                  sr_wpen <= rx_byte[7];
                  sr_wd   <= rx_byte[5:4];
                  sr_bl   <= rx_byte[3:2];
                  phase   <= PH_SDONE;
               end
               default: ;
            endcase
         end else if (bit_rise && phase == PH_SDONE) begin
            phase <= PH_DROP;
         end
         if (wt_done) st_wel <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (byte_done && phase == PH_WDAT) page_buf[slot] <= rx_byte;
   end

   always_ff @(posedge clk) begin
      if (commit_wr && !page_lock) begin
         for (int i = 0; i < PAGE; i++) begin
            if (page_vld[i])
               mem[{cur_addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= page_buf[i];
         end
      end
   end

   // a write cycle only ever starts while write-enable is held
   assert_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> $past(st_wel));
   // write-enable is gone once the cycle ends
   assert_wel_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wip) |=> !st_wel);
   // locked status register keeps its stored fields
   assert_sr_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sr_lock |=> $stable({st_wpen, st_wd, st_bl}));
   // the flag never changes through a status write commit
   assert_flag_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      commit_sr |=> $stable(st_flag));
endmodule

// File: tb/eep_cmd_engine_bench.sv
module eep_cmd_engine_bench;
   localparam int unsigned TICKS = 400;
   localparam int H = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
   logic miso, miso_oe;

   always #10 clk = ~clk;

   eep_cmd_engine #(.WR_TICKS(TICKS)) u_eep_cmd_engine (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
      .spi_mosi(mosi), .wp_n(wp_n), .spi_miso(miso), .spi_miso_oe(miso_oe)
   );

   int n_chk = 0, n_fail = 0;
   logic m3 = 1'b0;
   logic pend = 1'b0;
   logic m_wpen = 1'b0, m_flag = 1'b0, m_wel = 1'b0;
   logic [1:0] m_wd = 2'b11, m_bl = 2'b00;
   logic [7:0] mdl [4096];
   logic       known [4096];
   logic [7:0] wbuf [40];
   logic [7:0] rbuf [8];

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_st(input logic busy);
      return {m_wpen, m_flag, m_wd, m_bl, m_wel, busy};
   endfunction

   function automatic logic lock_m(input logic [11:0] a);
      case (m_bl)
         2'b00:   return 1'b0;
         2'b01:   return a[11:10] == 2'b11;
         2'b10:   return a[11];
         default: return 1'b1;
      endcase
   endfunction

   task automatic bit_x(input logic b, output logic r);
      sck = 1'b0; mosi = b; waitc(H);
      r = miso; sck = 1'b1; waitc(H);
   endtask

   task automatic byte_x(input logic [7:0] t, output logic [7:0] r);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_x(t[i], b);
         r[i] = b;
      end
   endtask

   task automatic cs_begin();
      sck = m3; waitc(H); cs_n = 1'b0; waitc(H);
   endtask

   task automatic cs_end();
      if (!m3) sck = 1'b0;
      waitc(H); cs_n = 1'b1; waitc(2 * H);
   endtask

   task automatic settle();
      if (pend) begin
         waitc(TICKS + 20);
         m_wel = 1'b0;
         pend = 1'b0;
      end
   endtask

   task automatic op1(input logic [7:0] op);
      logic [7:0] d;
      cs_begin(); byte_x(op, d); cs_end();
      if (!pend) begin
         if (op == 8'h06) m_wel = 1'b1;
         if (op == 8'h04) begin m_wel = 1'b0; m_flag = 1'b0; end
         if (op == 8'h00) m_flag = 1'b1;
      end
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] d;
      cs_begin(); byte_x(8'h05, d); byte_x(8'h00, s); cs_end();
   endtask

   task automatic do_write(input logic [15:0] a, input int n, input int extra);
      logic [7:0] d;
      logic b;
      logic [11:0] ad;
      cs_begin();
      byte_x(8'h02, d); byte_x(a[15:8], d); byte_x(a[7:0], d);
      for (int k = 0; k < n; k++) byte_x(wbuf[k], d);
      for (int k = 0; k < extra; k++) bit_x(1'b1, b);
      cs_end();
      if (m_wel && n > 0 && extra == 0) begin
         pend = 1'b1;
         for (int k = 0; k < n; k++) begin
            ad = {a[11:5], 5'(a[4:0] + 5'(k))};
            if (!lock_m(ad)) begin mdl[ad] = wbuf[k]; known[ad] = 1'b1; end
         end
      end
   endtask

   task automatic wrsr(input logic [7:0] v);
      logic [7:0] d;
      cs_begin(); byte_x(8'h01, d); byte_x(v, d); cs_end();
      if (m_wel && !(m_wpen && !wp_n)) begin
         m_wpen = v[7]; m_wd = v[5:4]; m_bl = v[3:2]; pend = 1'b1;
      end
   endtask

   task automatic check_read(input logic [15:0] a, input int n, input string tag);
      logic [7:0] d;
      logic [11:0] ad;
      cs_begin();
      byte_x(8'h03, d); byte_x(a[15:8], d); byte_x(a[7:0], d);
      for (int k = 0; k < n; k++) byte_x(8'h00, rbuf[k]);
      cs_end();
      for (int k = 0; k < n; k++) begin
         ad = a[11:0] + 12'(k);
         if (known[ad]) chk(tag, rbuf[k], mdl[ad]);
      end
   endtask

   task automatic wr1(input logic [15:0] a, input logic [7:0] v);
      op1(8'h06); wbuf[0] = v; do_write(a, 1, 0); settle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] s;
      logic [15:0] ra;
      int rn;
      for (int i = 0; i < 4096; i++) known[i] = 1'b0;
      waitc(10); rst_n = 1'b1; waitc(5);

      chk("R1 oe low while deselected", {7'd0, miso_oe}, 8'h00);
      rdsr(s); chk("R1 reset status", s, 8'h30);
      cs_begin(); waitc(4);
      chk("R1 oe high while selected", {7'd0, miso_oe}, 8'h01);
      cs_end();

      op1(8'h00); rdsr(s); chk("R2 set flag", s, exp_st(1'b0));
      op1(8'h06); rdsr(s); chk("R2 set write enable", s, exp_st(1'b0));
      op1(8'h04); rdsr(s); chk("R2 clear wel and flag", s, 8'h30);

      // first page write, busy phase and ignored command
      op1(8'h06);
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
      do_write(16'h0105, 3, 0);
      rdsr(s); chk("R8 busy and wel during cycle", s, exp_st(1'b1));
      op1(8'h00);
      settle();
      rdsr(s); chk("R8 cycle over, flag ignored, wel clear", s, exp_st(1'b0));
      check_read(16'h0105, 3, "R4 sequential read");
      check_read(16'hF105, 2, "R4 upper address bits ignored");

      wbuf[0] = 8'h11; do_write(16'h0105, 1, 0); settle();
      check_read(16'h0105, 1, "R5 write without wel ignored");

      op1(8'h06);
      wbuf[0] = 8'h10; wbuf[1] = 8'h11; wbuf[2] = 8'h12; wbuf[3] = 8'h13;
      do_write(16'h011E, 4, 0); settle();
      check_read(16'h011E, 2, "R6 page tail");
      check_read(16'h0100, 2, "R6 wrapped to page start");

      op1(8'h06);
      wbuf[0] = 8'h77; do_write(16'h0105, 1, 3);
      rdsr(s); chk("R7 mid-byte abort starts no cycle", s, exp_st(1'b0));
      check_read(16'h0105, 1, "R7 aborted data discarded");
      do_write(16'h0105, 0, 0);
      rdsr(s); chk("R7 no data byte no cycle", s, exp_st(1'b0));
      op1(8'h04);

      m3 = 1'b1; wr1(16'h0FFF, 8'h5A); m3 = 1'b0;
      wr1(16'h0000, 8'hA5);
      check_read(16'h0FFF, 2, "R4 read wraps to zero");
      m3 = 1'b1;
      check_read(16'h0FFF, 2, "R3 mode 3 read");
      rdsr(s); chk("R3 mode 3 status", s, exp_st(1'b0));
      m3 = 1'b0;
      wr1(16'h0C10, 8'h66); wr1(16'h0B00, 8'h55); wr1(16'h07F0, 8'h33);

      wrsr(8'h47); settle();
      rdsr(s); chk("R5 status write without wel ignored", s, exp_st(1'b0));
      op1(8'h06); wrsr(8'h47); settle();
      rdsr(s); chk("R10 only fields 7,5,4,3,2 written", s, 8'h04);

      wr1(16'h0C10, 8'h70); check_read(16'h0C10, 1, "R9 quarter lock blocks top");
      wr1(16'h0B00, 8'h88); check_read(16'h0B00, 1, "R9 quarter lock leaves below");
      op1(8'h06); wrsr(8'h08); settle();
      wr1(16'h0B00, 8'h99); check_read(16'h0B00, 1, "R9 half lock blocks upper half");
      wr1(16'h07F0, 8'h34); check_read(16'h07F0, 1, "R9 half lock leaves lower half");
      op1(8'h06); wrsr(8'h0C); settle();
      wr1(16'h0000, 8'h01); check_read(16'h0000, 1, "R9 full lock, data readable");

      op1(8'h06); wrsr(8'h80); settle();
      rdsr(s); chk("R11 lock enable set", s, 8'h80);
      wp_n = 1'b0; waitc(4);
      op1(8'h06); wrsr(8'h30); settle();
      rdsr(s); chk("R11 locked status write refused", s, 8'h82);
      wp_n = 1'b1; waitc(4);
      wrsr(8'h30); settle();
      rdsr(s); chk("R11 pin high allows write", s, 8'h30);
      wp_n = 1'b0; waitc(4);
      op1(8'h06); wrsr(8'h00); settle();
      rdsr(s); chk("R11 pin ignored when enable clear", s, 8'h00);
      wp_n = 1'b1;

      void'($urandom(32'd2024));
      for (int it = 0; it < 12; it++) begin
         ra = 16'($urandom());
         rn = 1 + int'($urandom() % 4);
         m3 = 1'($urandom());
         for (int k = 0; k < rn; k++) wbuf[k] = 8'($urandom());
         op1(8'h06); do_write(ra, rn, 0); settle();
         for (int k = 0; k < rn; k++)
            check_read({4'h0, ra[11:5], 5'(ra[4:0] + 5'(k))}, 1, "R6 random page write");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule